// File: doc/BRIEF.md
# Autoscan Acquisition Sequencer with Cascaded Pacer

This block sequences conversions for a 16-channel analog front end. Software programs it through a small byte-wide register port. The registers choose the trigger source, the channel, the input range and the pacer divisors. Each accepted trigger sends a one-cycle start pulse to the converter along with the channel and range. When the converter answers with its done strobe, the block captures the returned 16-bit word and passes it downstream tagged with its channel.

Three trigger sources exist. The first is a software strobe, which is any write to a dedicated offset. The second is an internal pacer made of two cascaded rate-generator counters, clocked from a 500 ns timebase derived from the system clock. The third is an external pin, which is synchronized and edge-detected. With autoscan enabled, the channel register holds the last channel of a scan. Successive conversions then walk from channel 0 up to that channel and wrap back to 0. A trigger that arrives while a conversion is still outstanding is discarded and recorded in a sticky flag, which a status read clears.

Top module: `acq_sequencer`

## Requirements
- R1: The mode register at offset 0 holds 4 bits and reads back at the same offset with the upper 4 bits zero. Bit0 is autoscan enable, bit1 selects the pacer (1) or software (0), bit2 selects the external source (1) and overrides bit1, and bit3 is the pretrigger flag.
- R2: With autoscan off, every conversion uses the channel held in the 4-bit channel register at offset 1. That register reads back at offset 1.
- R3: With autoscan on, conversions use channels 0, 1, … up to the channel register value and then wrap to 0. Any write to offset 0 or offset 1 restarts the scan at channel 0.
- R4: When bit1 and bit2 of the mode register are both 0, a write of any value to offset 3 starts exactly one conversion, and conv_start is high in the cycle after the write. Under any other mode such a write starts nothing.
- R5: Each pacer divisor is loaded through a byte port, low byte first and then high byte: offset 4 for the first stage and offset 5 for the second. The high-byte write reloads that stage. A divisor of 0 counts as 65536. With the pacer selected, conversions are spaced TICK_DIV × D1 × D2 clock cycles apart.
- R6: With bit2 of the mode register set, each rising edge of ext_trig starts one conversion, and conv_start rises in the cycle after the third clock edge that sees the high level. Pacer pulses and software writes are then ignored.
- R7: The 3-bit range register at offset 2 drives conv_range for every conversion and reads back at offset 2.
- R8: A conv_done while a conversion is outstanding produces a one-cycle sample_valid in the next cycle. It carries the conv_data value and the channel of that conversion.
- R9: Status bit7 at offset 6 reads 1 from the accepted trigger until conv_done.
- R10: A selected trigger that arrives while a conversion is outstanding starts nothing and sets status bit0. A read of offset 6 returns the flag and then clears it.
- R11: After reset, all registers read 0, no conversion is outstanding, both divisors are 65536, and every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; rdata updates one cycle later |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered, held between reads |
| ext_trig | input | 1 | Asynchronous external trigger pin |
| conv_start | output | 1 | One-cycle conversion start pulse |
| conv_chan | output | 4 | Channel for the conversion |
| conv_range | output | 3 | Input range for all channels |
| conv_done | input | 1 | Converter completion strobe |
| conv_data | input | DATA_W | Converter result, valid with conv_done |
| sample_valid | output | 1 | Captured sample strobe |
| sample_data | output | DATA_W | Captured converter word |
| sample_chan | output | 4 | Channel of the captured word |

## Verification
The assertions assume three things about the converter. It raises conv_done only while a conversion is outstanding. It never raises conv_done in the same cycle as the start pulse. It holds conv_data valid whenever conv_done is high. The bench's converter model meets all three, because it answers each start pulse once after a programmable latency. The bench also keeps ext_trig high for at least two clocks so that the synchronizer sees every edge. It sets pacer periods well above the converter latency, except in the deliberate overrun case, which lengthens the latency instead.

// File: rtl/acq_pkg.sv
package acq_pkg;
  localparam int unsigned CHAN_W  = 4;
  localparam int unsigned RANGE_W = 3;
  localparam int unsigned MODE_W  = 4;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned DIV_W   = 2 * BYTE_W;
  localparam int unsigned CNT_W   = DIV_W + 1;

  localparam logic [2:0] OFS_MODE  = 3'd0;
  localparam logic [2:0] OFS_CHAN  = 3'd1;
  localparam logic [2:0] OFS_RANGE = 3'd2;
  localparam logic [2:0] OFS_SWTRG = 3'd3;
  localparam logic [2:0] OFS_DIV1  = 3'd4;
  localparam logic [2:0] OFS_DIV2  = 3'd5;
  localparam logic [2:0] OFS_STAT  = 3'd6;

  typedef enum logic [1:0] {SRC_SOFT, SRC_PACE, SRC_EXT} trig_src_e;

  // Divisor value to count span: zero stands for the full 2^DIV_W.
  function automatic logic [CNT_W-1:0] span_of(input logic [DIV_W-1:0] d);
    return (d == '0) ? {1'b1, {DIV_W{1'b0}}} : {1'b0, d};
  endfunction

  // Next scan channel: walk upward from 0 and wrap after the last one.
  function automatic logic [CHAN_W-1:0] scan_next(input logic [CHAN_W-1:0] cur,
                                                  input logic [CHAN_W-1:0] last);
    return (cur >= last) ? '0 : cur + 1'b1;
  endfunction

  // The external select bit dominates, then the pacer select bit.
  function automatic trig_src_e src_of(input logic [MODE_W-1:0] mode);
    if (mode[2])      return SRC_EXT;
    else if (mode[1]) return SRC_PACE;
    else              return SRC_SOFT;
  endfunction
endpackage

// File: rtl/acq_rate_stage.sv
module acq_rate_stage
  import acq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_we,
  input  logic [BYTE_W-1:0] byte_val,
  input  logic              en,
  output logic              pulse
);
  logic              hi_next;
  logic [BYTE_W-1:0] lo_q;
  logic [DIV_W-1:0]  div_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              load;
  logic [DIV_W-1:0]  load_val;

  assign load     = byte_we & hi_next;
  assign load_val = {byte_val, lo_q};
  assign pulse    = en && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_next <= 1'b0;
      lo_q    <= '0;
      div_q   <= '0;
      cnt_q   <= span_of('0);
    end else begin
      if (byte_we) begin
        hi_next <= ~hi_next;
        if (!hi_next) lo_q <= byte_val;
      end
      if (load) begin
        div_q <= load_val;
        cnt_q <= span_of(load_val);
      end else if (en) begin
        cnt_q <= (cnt_q == CNT_W'(1)) ? span_of(div_q) : cnt_q - 1'b1;
      end
    end
  end

  // R5: after an output pulse the stage restarts from its full divisor span
  a_r5_reload_span: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && !load) |=> (cnt_q == span_of(div_q)));
  // R5: a high-byte write restarts the count from the new divisor
  a_r5_load_restart: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == span_of($past(load_val))));
endmodule

// File: rtl/acq_pacer.sv
module acq_pacer
  import acq_pkg::*;
#(
  parameter int unsigned TICK_DIV = 25,
  parameter int unsigned STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAGES-1:0] div_we,
  input  logic [BYTE_W-1:0] wdata,
  output logic              pace
);
  localparam int unsigned PRE_W = $clog2(TICK_DIV + 1);

  logic [PRE_W-1:0] pre_q;
  logic             tick;
  logic [STAGES:0]  chain;

  assign tick     = (pre_q == PRE_W'(TICK_DIV - 1));
  assign chain[0] = tick;
  assign pace     = chain[STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pre_q <= '0;
    else if (tick) pre_q <= '0;
    else           pre_q <= pre_q + 1'b1;
  end

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    acq_rate_stage u_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .byte_we  (div_we[k]),
      .byte_val (wdata),
      .en       (chain[k]),
      .pulse    (chain[k+1])
    );
  end

  // R5: the cascaded output only fires on a timebase tick
  a_r5_pace_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    pace |-> tick);
endmodule

// File: rtl/acq_edge_sync.sv
module acq_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic s1_q, s2_q, s3_q;

  assign rise = s2_q & ~s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= async_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  // R6: one rise per edge, never two cycles in a row
  a_r6_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/acq_core.sv
module acq_core
  import acq_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_en,
  input  logic [CHAN_W-1:0] chan_reg,
  input  logic              ptr_clear,
  input  logic              trig,
  input  logic              ovr_clear,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  output logic              conv_start,
  output logic [CHAN_W-1:0] conv_chan,
  output logic              busy,
  output logic              overrun,
  output logic              sample_valid,
  output logic [DATA_W-1:0] sample_data,
  output logic [CHAN_W-1:0] sample_chan
);
  logic [CHAN_W-1:0] ptr_q;
  logic              start_ok;
  logic              drop;
  logic              finish;

  assign start_ok = trig & ~busy;
  assign drop     = trig & busy;
  assign finish   = conv_done & busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q        <= '0;
      conv_start   <= 1'b0;
      conv_chan    <= '0;
      busy         <= 1'b0;
      overrun      <= 1'b0;
      sample_valid <= 1'b0;
      sample_data  <= '0;
      sample_chan  <= '0;
    end else begin
      conv_start   <= start_ok;
      sample_valid <= finish;
      if (start_ok) conv_chan <= scan_en ? ptr_q : chan_reg;
      if (finish) begin
        sample_data <= conv_data;
        sample_chan <= conv_chan;
      end
      if (start_ok)    busy <= 1'b1;
      else if (finish) busy <= 1'b0;
      if (drop)           overrun <= 1'b1;
      else if (ovr_clear) overrun <= 1'b0;
      if (ptr_clear)              ptr_q <= '0;
      else if (finish && scan_en) ptr_q <= scan_next(ptr_q, chan_reg);
    end
  end

  // R8: a completed conversion yields a sample in the next cycle
  a_r8_sample_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && busy) |=> (sample_valid && sample_data == $past(conv_data)));
  // R9: an issued start leaves the conversion outstanding
  a_r9_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> busy);
  // R4: starts never come back to back
  a_r4_single_start: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  // R3: a scanned channel never exceeds the programmed last channel
  a_r3_chan_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && $past(scan_en)) |-> (conv_chan <= $past(chan_reg)));
  // R10: a trigger while outstanding leaves the flag set
  a_r10_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && busy) |=> overrun);
  // R10: a status read without a new overrun clears the flag
  a_r10_overrun_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_clear && !(trig && busy)) |=> !overrun);
endmodule

// File: rtl/acq_sequencer.sv
module acq_sequencer
  import acq_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned TICK_DIV = 25
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [2:0]         addr,
  input  logic [BYTE_W-1:0]  wdata,
  output logic [BYTE_W-1:0]  rdata,
  input  logic               ext_trig,
  output logic               conv_start,
  output logic [CHAN_W-1:0]  conv_chan,
  output logic [RANGE_W-1:0] conv_range,
  input  logic               conv_done,
  input  logic [DATA_W-1:0]  conv_data,
  output logic               sample_valid,
  output logic [DATA_W-1:0]  sample_data,
  output logic [CHAN_W-1:0]  sample_chan
);
  logic [MODE_W-1:0]  mode_q;
  logic [CHAN_W-1:0]  chan_q;
  logic [RANGE_W-1:0] range_q;
  logic               sw_strobe, pace, ext_rise, trig;
  logic               ptr_clear, ovr_clear, busy, overrun;
  logic [1:0]         div_we;
  trig_src_e          src;

  assign src       = src_of(mode_q);
  assign sw_strobe = wr_en && (addr == OFS_SWTRG);
  assign ptr_clear = wr_en && ((addr == OFS_MODE) || (addr == OFS_CHAN));
  assign ovr_clear = rd_en && (addr == OFS_STAT);
  assign div_we    = {wr_en && (addr == OFS_DIV2), wr_en && (addr == OFS_DIV1)};
  assign conv_range = range_q;

  always_comb begin
    unique case (src)
      SRC_EXT:  trig = ext_rise;
      SRC_PACE: trig = pace;
      default:  trig = sw_strobe;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      chan_q  <= '0;
      range_q <= '0;
      rdata   <= '0;
    end else begin
      if (wr_en) begin
        if (addr == OFS_MODE)  mode_q  <= wdata[MODE_W-1:0];
        if (addr == OFS_CHAN)  chan_q  <= wdata[CHAN_W-1:0];
        if (addr == OFS_RANGE) range_q <= wdata[RANGE_W-1:0];
      end
      if (rd_en) begin
        case (addr)
          OFS_MODE:  rdata <= BYTE_W'(mode_q);
          OFS_CHAN:  rdata <= BYTE_W'(chan_q);
          OFS_RANGE: rdata <= BYTE_W'(range_q);
          OFS_STAT:  rdata <= {busy, {(BYTE_W-2){1'b0}}, overrun};
          default:   rdata <= '0;
        endcase
      end
    end
  end

  acq_pacer #(.TICK_DIV(TICK_DIV), .STAGES(2)) u_pacer (
    .clk    (clk),
    .rst_n  (rst_n),
    .div_we (div_we),
    .wdata  (wdata),
    .pace   (pace)
  );

  acq_edge_sync u_ext (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (ext_trig),
    .rise     (ext_rise)
  );

  acq_core #(.DATA_W(DATA_W)) u_core (
    .clk          (clk),
    .rst_n        (rst_n),
    .scan_en      (mode_q[0]),
    .chan_reg     (chan_q),
    .ptr_clear    (ptr_clear),
    .trig         (trig),
    .ovr_clear    (ovr_clear),
    .conv_done    (conv_done),
    .conv_data    (conv_data),
    .conv_start   (conv_start),
    .conv_chan    (conv_chan),
    .busy         (busy),
    .overrun      (overrun),
    .sample_valid (sample_valid),
    .sample_data  (sample_data),
    .sample_chan  (sample_chan)
  );

  // R4: a software strobe is ignored unless the software source is selected
  a_r4_soft_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_strobe && (mode_q[2:1] != 2'b00) && !pace && !ext_rise) |=> !conv_start);
  // R7: the range output follows the last range write
  a_r7_range_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_RANGE) |=> (conv_range == $past(wdata[RANGE_W-1:0])));
endmodule

// File: tb/acq_sequencer_bench.sv
module acq_sequencer_bench;
  localparam int TICK = 25;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        ext_trig = 1'b0;
  logic        conv_start;
  logic [3:0]  conv_chan;
  logic [2:0]  conv_range;
  logic        conv_done = 1'b0;
  logic [15:0] conv_data = '0;
  logic        sample_valid;
  logic [15:0] sample_data;
  logic [3:0]  sample_chan;

  int checks = 0, errors = 0;
  int cyc = 0, n_start = 0, last_start = 0, gap = 0;
  int lat = 4, cd = 0, seq = 0;
  logic [3:0] held_chan = '0;
  logic [3:0] chan_log[$];

  always #10 clk = ~clk;

  acq_sequencer #(.DATA_W(16), .TICK_DIV(TICK)) u_acq_sequencer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ext_trig(ext_trig), .conv_start(conv_start),
    .conv_chan(conv_chan), .conv_range(conv_range), .conv_done(conv_done),
    .conv_data(conv_data), .sample_valid(sample_valid), .sample_data(sample_data),
    .sample_chan(sample_chan)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // Converter model: answers each start once after lat cycles.
  always @(negedge clk) begin
    conv_done = 1'b0;
    if (cd > 0) begin
      cd--;
      if (cd == 0) begin
        conv_done = 1'b1;
        conv_data = {4'hC, held_chan, seq[7:0]};
        seq++;
      end
    end
    if (conv_start === 1'b1) begin
      cd = lat;
      held_chan = conv_chan;
    end
  end

  // Behavioural reference model
  bit [3:0]  m_mode, m_chan, m_ptr, m_cchan, m_schan;
  bit [2:0]  m_range;
  int        m_pre, m_cnt[2], m_div[2], m_lo[2];
  bit        m_hi[2];
  bit        m_s1, m_s2, m_s3, m_busy, m_ovr, m_start, m_sv;
  bit [15:0] m_sdata;
  bit [7:0]  m_rdata;
  string     m_rtag = "R11";

  function automatic int span(input int d);
    return (d == 0) ? 65536 : d;
  endfunction

  task automatic model_reset();
    m_mode = 0; m_chan = 0; m_ptr = 0; m_cchan = 0; m_schan = 0; m_range = 0;
    m_pre = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0; m_busy = 0; m_ovr = 0;
    m_start = 0; m_sv = 0; m_sdata = 0; m_rdata = 0;
    for (int k = 0; k < 2; k++) begin
      m_cnt[k] = 65536; m_div[k] = 0; m_lo[k] = 0; m_hi[k] = 0;
    end
  endtask

  task automatic model_step();
    bit en, pls, rise, trig, fin, st;
    en = (m_pre == TICK - 1);
    m_pre = en ? 0 : m_pre + 1;
    for (int k = 0; k < 2; k++) begin
      bit wsel, ld;
      pls  = en && (m_cnt[k] == 1);
      wsel = wr_en && (addr == 3'(4 + k));
      ld   = wsel && m_hi[k];
      if (wsel) begin
        if (!m_hi[k]) m_lo[k] = int'(wdata);
        m_hi[k] = !m_hi[k];
      end
      if (ld) begin
        m_div[k] = int'(wdata) * 256 + m_lo[k];
        m_cnt[k] = span(m_div[k]);
      end else if (en) begin
        m_cnt[k] = (m_cnt[k] == 1) ? span(m_div[k]) : m_cnt[k] - 1;
      end
      en = pls;
    end
    rise = m_s2 && !m_s3;
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_trig;
    if (m_mode[2])      trig = rise;
    else if (m_mode[1]) trig = en;
    else                trig = wr_en && (addr == 3'd3);
    fin = conv_done && m_busy;
    st  = trig && !m_busy;
    if (rd_en) begin
      case (addr)
        3'd0: begin m_rdata = {4'b0, m_mode}; m_rtag = "R1"; end
        3'd1: begin m_rdata = {4'b0, m_chan}; m_rtag = "R2"; end
        3'd2: begin m_rdata = {5'b0, m_range}; m_rtag = "R7"; end
        3'd6: begin m_rdata = {m_busy, 6'b0, m_ovr}; m_rtag = "R10"; end
        default: begin m_rdata = 8'h00; m_rtag = "R11"; end
      endcase
    end
    if (trig && m_busy) m_ovr = 1;
    else if (rd_en && addr == 3'd6) m_ovr = 0;
    m_sv = fin;
    if (fin) begin m_sdata = conv_data; m_schan = m_cchan; end
    m_start = st;
    if (st) m_cchan = m_mode[0] ? m_ptr : m_chan;
    if (st) m_busy = 1; else if (fin) m_busy = 0;
    if (wr_en && (addr == 3'd0 || addr == 3'd1)) m_ptr = 0;
    else if (fin && m_mode[0]) m_ptr = (m_ptr >= m_chan) ? 4'd0 : m_ptr + 4'd1;
    if (wr_en && addr == 3'd0) m_mode = wdata[3:0];
    if (wr_en && addr == 3'd1) m_chan = wdata[3:0];
    if (wr_en && addr == 3'd2) m_range = wdata[2:0];
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else model_step();
    #5;
    cyc++;
    chk("R4 conv_start", 32'(conv_start), 32'(m_start));
    chk("R3 conv_chan", 32'(conv_chan), 32'(m_cchan));
    chk("R7 conv_range", 32'(conv_range), 32'(m_range));
    chk("R8 sample_valid", 32'(sample_valid), 32'(m_sv));
    chk("R8 sample_data", 32'(sample_data), 32'(m_sdata));
    chk("R8 sample_chan", 32'(sample_chan), 32'(m_schan));
    chk({m_rtag, " rdata"}, 32'(rdata), 32'(m_rdata));
    if (conv_start === 1'b1) begin
      gap = cyc - last_start;
      last_start = cyc;
      n_start++;
    end
    if (sample_valid === 1'b1) chan_log.push_back(sample_chan);
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    int base;
    idle(3);
    rst_n = 1'b1;
    // R11: reset state
    rd(3'd0, v); chk("R11 mode reset", 32'(v), 32'h0);
    rd(3'd1, v); chk("R11 chan reset", 32'(v), 32'h0);
    rd(3'd2, v); chk("R11 range reset", 32'(v), 32'h0);
    rd(3'd6, v); chk("R11 status reset", 32'(v), 32'h0);
    // R1: mode readback, upper bits dropped
    wr(3'd0, 8'hF9); rd(3'd0, v); chk("R1 mode readback", 32'(v), 32'h09);
    wr(3'd0, 8'h00); rd(3'd0, v); chk("R1 mode cleared", 32'(v), 32'h00);
    // R2, R7, R8: single channel software conversion
    wr(3'd2, 8'h05); wr(3'd1, 8'h07);
    rd(3'd1, v); chk("R2 chan readback", 32'(v), 32'h07);
    rd(3'd2, v); chk("R7 range readback", 32'(v), 32'h05);
    chan_log.delete();
    wr(3'd3, 8'h5A); idle(10);
    chk("R2 sample count", 32'(chan_log.size()), 32'd1);
    if (chan_log.size() > 0) chk("R2 sample channel", 32'(chan_log[0]), 32'd7);
    // R3: autoscan 0..2 wraps
    wr(3'd0, 8'h01); wr(3'd1, 8'h02);
    chan_log.delete();
    for (int i = 0; i < 5; i++) begin wr(3'd3, 8'(i)); idle(8); end
    chk("R3 scan count", 32'(chan_log.size()), 32'd5);
    if (chan_log.size() == 5) begin
      chk("R3 scan ch0", 32'(chan_log[0]), 32'd0);
      chk("R3 scan ch2", 32'(chan_log[2]), 32'd2);
      chk("R3 scan wrap", 32'(chan_log[3]), 32'd0);
      chk("R3 scan ch1", 32'(chan_log[4]), 32'd1);
    end
    wr(3'd1, 8'h02); chan_log.delete();
    wr(3'd3, 8'h00); idle(8);
    if (chan_log.size() > 0) chk("R3 restart at 0", 32'(chan_log[0]), 32'd0);
    // R9, R10: overrun while outstanding
    lat = 30;
    wr(3'd3, 8'h00); idle(2); wr(3'd3, 8'h00);
    rd(3'd6, v); chk("R10 overrun and R9 busy", 32'(v), 32'h81);
    idle(35);
    rd(3'd6, v); chk("R10 overrun cleared", 32'(v), 32'h00);
    lat = 4;
    // R4: software strobe ignored when the pacer is selected
    wr(3'd0, 8'h02); base = n_start;
    wr(3'd3, 8'hFF); idle(10);
    chk("R4 soft ignored", 32'(n_start - base), 32'd0);
    // R5: pacer with divisors 2 and 3
    wr(3'd4, 8'h02); wr(3'd4, 8'h00);
    wr(3'd5, 8'h03); wr(3'd5, 8'h00);
    idle(700);
    chk("R5 pacer spacing", 32'(gap), 32'(TICK * 2 * 3));
    // R5: divisor zero means 65536
    wr(3'd4, 8'h00); wr(3'd4, 8'h00);
    idle(20); base = n_start; idle(2000);
    chk("R5 zero divisor slow", 32'(n_start - base), 32'd0);
    wr(3'd4, 8'h02); wr(3'd4, 8'h00);
    // R6: external overrides the pacer
    wr(3'd0, 8'h06); idle(5); base = n_start;
    for (int i = 0; i < 3; i++) begin
      ext_trig = 1'b1; idle(3); ext_trig = 1'b0; idle(40);
    end
    chk("R6 external count", 32'(n_start - base), 32'd3);
    idle(20);
    finish_run();
  end
endmodule